// File: doc/BRIEF.md
# Mangle Phase Delay Timer

This block decides when the next bit-exchange transaction may begin once both state tables have been through their update (mangle) phase. When the load strobe is given, it reads the iteration-count nibble of each of the two tables. From these it presets a down-counter to the shortest possible duration of the update phase. In that estimate every iteration is assumed to be short, and a fixed overhead per table is added on top.

While the update runs, the calculation logic pulses a long-iteration strobe each time an iteration turns out to be of the long kind. Each such pulse stretches the remaining delay. When the count runs out, the block emits a one-cycle interrupt and switches into slot mode. In slot mode the counter reloads itself with the exchange slot period and interrupts again at the end of every slot. A service routine can therefore answer late, as long as it answers before the next slot ends.

Time is counted in ticks. A tick is a cycle in which the tick enable is high. The mangle arithmetic itself is not part of this block.

Top module: `mangle_delay_timer`

## Requirements
- R1: After synchronous reset, `irq`, `slot_mode` and `late_err` are 0. Without a load, the block stays idle and never raises `irq`, whatever `tick_en` does.
- R2: A load presets the delay to 78 × (A + B) + 58 ticks, where A and B are the iteration counts taken from `count_a` and `count_b`. `irq` goes high in the cycle after the edge that samples the last of those ticks, counting only ticks sampled at edges after the load edge.
- R3: Each `long_strb` sampled while in delay mode adds 6 ticks to the remaining delay. A tick sampled at the same edge still counts.
- R4: Cycles with `tick_en` low do not advance the count, in either mode.
- R5: `irq` is high for exactly one cycle per expiry. `slot_mode` rises at the same edge as the first `irq`.
- R6: In slot mode, `irq` repeats every 79 ticks, measured from the previous expiry, and `slot_mode` stays 1.
- R7: A `long_strb` sampled while idle or in slot mode sets `late_err` and does not change the timing. `late_err` stays set until the next load.
- R8: A load takes priority in every mode. It rearms the delay, clears `late_err` and drives `slot_mode` to 0. A `long_strb` or tick in the load cycle is ignored.
- R9: An iteration-count nibble of 0 counts as one iteration. Values 1 to 15 count as themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One timing tick when high |
| load_strb | input | 1 | Preload the delay from the two nibbles |
| count_a | input | 4 | Iteration-count nibble of the first table |
| count_b | input | 4 | Iteration-count nibble of the second table |
| long_strb | input | 1 | One long iteration was found |
| irq | output | 1 | Single-cycle expiry interrupt |
| slot_mode | output | 1 | 0 = idle or delay mode, 1 = 79-tick slot mode |
| late_err | output | 1 | Sticky flag for a long strobe that arrived outside delay mode |

## Verification
Every result is registered once.

- An expiry sampled at an edge shows `irq` and `slot_mode` directly after that edge.
- A late strobe shows `late_err` one edge later.
- A load changes the outputs one edge after it is sampled.

The bench drives its inputs just after each rising edge and updates a behavioural integer model at the same edge. It compares all three outputs at the following falling edge, so every result is checked in the exact cycle it becomes due. A directed run also counts the cycles from load to interrupt, to confirm the preload value independently of the model.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    localparam int CNT_W       = 12;
    localparam int NIB_W       = 4;
    localparam int NUM_TABLES  = 2;
    localparam int SHORT_COST  = 78;
    localparam int LONG_EXTRA  = 6;
    localparam int TABLE_OVH   = 29;
    localparam int SLOT_PERIOD = 79;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_DELAY = 2'd1,
        MODE_SLOT  = 2'd2
    } mode_e;

    typedef struct packed {
        logic load;
        logic tick;
        logic long_it;
    } ctl_t;

    // Iteration count from a nibble: zero is treated as a single pass.
    function automatic int iter_count(input logic [NIB_W-1:0] nib);
        return (nib == '0) ? 1 : int'(nib);
    endfunction

    // Minimum duration contributed by one table.
    function automatic int table_cost(input logic [NIB_W-1:0] nib,
                                      input int short_cost,
                                      input int ovh);
        return iter_count(nib) * short_cost + ovh;
    endfunction

endpackage

// File: rtl/mdt_preload.sv
module mdt_preload
    import mdt_pkg::*;
#(
    parameter int P_CNT_W      = CNT_W,
    parameter int P_NIB_W      = NIB_W,
    parameter int P_TABLES     = NUM_TABLES,
    parameter int P_SHORT_COST = SHORT_COST,
    parameter int P_TABLE_OVH  = TABLE_OVH
) (
    input  logic [P_TABLES-1:0][P_NIB_W-1:0] nibs,
    output logic [P_CNT_W-1:0]               preload
);
    localparam int MAX_COST = ((1 << P_NIB_W) - 1) * P_SHORT_COST + P_TABLE_OVH;

    int cost [P_TABLES];

    for (genvar t = 0; t < P_TABLES; t++) begin : g_tab
        always_comb begin
            cost[t] = table_cost(nibs[t], P_SHORT_COST, P_TABLE_OVH);
        end
    end

    always_comb begin
        int acc;
        acc = 0;
        for (int t = 0; t < P_TABLES; t++) begin
            acc = acc + cost[t];
        end
        preload = P_CNT_W'(acc);
    end

    // The largest possible preload must fit in the counter width.
    initial begin
        assert (P_TABLES * MAX_COST < (1 << P_CNT_W))
            else $error("counter too narrow for preload");
    end

endmodule

// File: rtl/mdt_counter.sv
module mdt_counter
    import mdt_pkg::*;
#(
    parameter int P_CNT_W      = CNT_W,
    parameter int P_LONG_EXTRA = LONG_EXTRA,
    parameter int P_SLOT       = SLOT_PERIOD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               do_load,
    input  logic [P_CNT_W-1:0] load_val,
    input  logic               active,
    input  logic               add_ext,
    input  logic               tick,
    output logic               expire
);
    localparam logic [P_CNT_W:0] SAT_MAX = {1'b0, {P_CNT_W{1'b1}}};

    logic [P_CNT_W-1:0] cnt_q;
    logic [P_CNT_W:0]   sum;
    logic [P_CNT_W-1:0] adj;

    always_comb begin
        sum = {1'b0, cnt_q} + (add_ext ? (P_CNT_W+1)'(P_LONG_EXTRA) : '0);
        adj = (sum > SAT_MAX) ? SAT_MAX[P_CNT_W-1:0] : sum[P_CNT_W-1:0];
        expire = active && tick && (adj == P_CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (do_load) begin
            cnt_q <= load_val;
        end else if (active) begin
            if (expire) begin
                cnt_q <= P_CNT_W'(P_SLOT);
            end else if (tick) begin
                cnt_q <= adj - P_CNT_W'(1);
            end else begin
                cnt_q <= adj;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (active && !do_load) |-> (cnt_q != '0)) else $error("armed counter at zero"); // R2

    AST_SLOT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (expire && !do_load) |=> (cnt_q == P_CNT_W'(P_SLOT))) else $error("no slot reload"); // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (active && !do_load && !tick && !add_ext) |=> $stable(cnt_q)) else $error("count moved"); // R4

endmodule

// File: rtl/mdt_ctrl.sv
module mdt_ctrl
    import mdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic expire,
    output logic active,
    output logic add_ext,
    output logic irq,
    output logic slot_mode,
    output logic late_err
);
    mode_e mode_q;
    logic  err_q;
    logic  irq_q;

    always_comb begin
        active    = (mode_q != MODE_IDLE);
        add_ext   = ctl.long_it && (mode_q == MODE_DELAY) && !ctl.load;
        irq       = irq_q;
        slot_mode = (mode_q == MODE_SLOT);
        late_err  = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl.load) begin
                mode_q <= MODE_DELAY;
                err_q  <= 1'b0;
            end else begin
                if (ctl.long_it && (mode_q != MODE_DELAY)) begin
                    err_q <= 1'b1;
                end
                if (expire) begin
                    irq_q  <= 1'b1;
                    mode_q <= MODE_SLOT;
                end
            end
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq wider than one cycle"); // R5

    AST_IRQ_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq |-> slot_mode) else $error("irq outside slot mode"); // R5

    AST_LOAD_REARM: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (!slot_mode && !late_err && !irq)) else $error("load did not rearm"); // R8

    AST_LATE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctl.long_it && !ctl.load && slot_mode) |=> late_err) else $error("late strobe missed"); // R7

    AST_SLOT_STAYS: assert property (@(posedge clk) disable iff (rst)
        (slot_mode && !ctl.load) |=> slot_mode) else $error("left slot mode"); // R6

endmodule

// File: rtl/mangle_delay_timer.sv
module mangle_delay_timer
    import mdt_pkg::*;
#(
    parameter int P_CNT_W = CNT_W,
    parameter int P_NIB_W = NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               load_strb,
    input  logic [P_NIB_W-1:0] count_a,
    input  logic [P_NIB_W-1:0] count_b,
    input  logic               long_strb,
    output logic               irq,
    output logic               slot_mode,
    output logic               late_err
);
    logic [NUM_TABLES-1:0][P_NIB_W-1:0] nibs;
    logic [P_CNT_W-1:0] preload;
    logic active, add_ext, expire;
    ctl_t ctl;

    assign nibs = {count_b, count_a};
    assign ctl  = '{load: load_strb, tick: tick_en, long_it: long_strb};

    mdt_preload #(
        .P_CNT_W(P_CNT_W), .P_NIB_W(P_NIB_W), .P_TABLES(NUM_TABLES),
        .P_SHORT_COST(SHORT_COST), .P_TABLE_OVH(TABLE_OVH)
    ) u_pre (
        .nibs(nibs), .preload(preload)
    );

    mdt_counter #(
        .P_CNT_W(P_CNT_W), .P_LONG_EXTRA(LONG_EXTRA), .P_SLOT(SLOT_PERIOD)
    ) u_cnt (
        .clk(clk), .rst(rst), .do_load(load_strb), .load_val(preload),
        .active(active), .add_ext(add_ext), .tick(tick_en), .expire(expire)
    );

    mdt_ctrl u_ctl (
        .clk(clk), .rst(rst), .ctl(ctl), .expire(expire), .active(active),
        .add_ext(add_ext), .irq(irq), .slot_mode(slot_mode), .late_err(late_err)
    );

endmodule

// File: tb/tb_mangle_delay_timer.sv
`timescale 1ns/1ps
module tb_mangle_delay_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0, load_strb = 1'b0, long_strb = 1'b0;
    logic [3:0] count_a = '0, count_b = '0;
    logic irq, slot_mode, late_err;

    int total = 0, bad = 0, cyc = 0;
    string cur = "R1";
    bit done = 0;

    // Behavioural reference model.
    int m_st = 0, m_cnt = 0;
    bit m_irq = 0, m_err = 0;

    always #2.5 clk = ~clk;

    mangle_delay_timer dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load_strb(load_strb),
        .count_a(count_a), .count_b(count_b), .long_strb(long_strb),
        .irq(irq), .slot_mode(slot_mode), .late_err(late_err)
    );

    always @(posedge clk) begin
        int a, b, adj;
        cyc++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_irq = 0; m_err = 0;
        end else begin
            m_irq = 0;
            if (load_strb) begin
                a = (count_a == 0) ? 1 : int'(count_a);
                b = (count_b == 0) ? 1 : int'(count_b);
                m_cnt = 78 * (a + b) + 58;
                m_st = 1; m_err = 0;
            end else begin
                if (long_strb && m_st != 1) m_err = 1;
                if (m_st != 0) begin
                    adj = m_cnt + ((long_strb && m_st == 1) ? 6 : 0);
                    if (tick_en) begin
                        if (adj == 1) begin m_irq = 1; m_cnt = 79; m_st = 2; end
                        else m_cnt = adj - 1;
                    end else m_cnt = adj;
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur, "irq", int'(irq), int'(m_irq));
            chk(cur, "slot_mode", int'(slot_mode), (m_st == 2) ? 1 : 0);
            chk(cur, "late_err", int'(late_err), int'(m_err));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_load(logic [3:0] a, logic [3:0] b);
        count_a = a; count_b = b; load_strb = 1'b1;
        step(1);
        load_strb = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        step(3);
        rst = 1'b0;
        // R1: reset state, and no irq when idle while ticking
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "slot after reset", int'(slot_mode), 0);
        tick_en = 1'b1;
        step(300);
        chk("R1", "idle never fires", int'(irq), 0);

        // R9: zero nibbles count as one iteration each -> 214 ticks
        cur = "R9";
        do_load(4'd0, 4'd0);
        k = 0;
        while (k < 400) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (irq) break;
        end
        chk("R9", "load-to-irq cycles", k, 214);
        #1;

        // R2 / R4: maximal preload with tick gated every third cycle
        cur = "R2";
        do_load(4'd15, 4'd15);
        for (int i = 0; i < 3700; i++) begin
            tick_en = (i % 3 != 0);
            step(1);
        end
        cur = "R4";
        tick_en = 1'b0;
        step(50);
        chk("R4", "no expiry without ticks", int'(slot_mode), (m_st == 2) ? 1 : 0);

        // R3: long strobes during delay, some on tick cycles
        cur = "R3";
        tick_en = 1'b1;
        do_load(4'd3, 4'd2);
        for (int i = 0; i < 500; i++) begin
            long_strb = (i % 37 == 5) && (i < 200);
            tick_en = (i % 5 != 2);
            step(1);
        end
        long_strb = 1'b0;

        // R5 / R6: slot mode repeats every 79 ticks
        cur = "R6";
        tick_en = 1'b1;
        step(400);
        cur = "R5";
        for (int i = 0; i < 200; i++) begin
            tick_en = (i % 2 == 0);
            step(1);
        end

        // R7: late strobe in slot mode sets sticky error, timing unchanged
        cur = "R7";
        tick_en = 1'b1;
        long_strb = 1'b1; step(1); long_strb = 1'b0;
        step(200);
        chk("R7", "late_err sticky", int'(late_err), 1);

        // R8: load from slot mode with long strobe in the same cycle
        cur = "R8";
        long_strb = 1'b1;
        do_load(4'd1, 4'd4);
        long_strb = 1'b0;
        chk("R8", "late_err cleared", int'(late_err), 0);
        chk("R8", "slot_mode cleared", int'(slot_mode), 0);
        step(100);
        do_load(4'd2, 4'd2);
        step(500);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule